// File: doc/BRIEF.md
# Interrupt-to-processor routing map

This block takes interrupt sources that have already been conditioned and masked, and steers each one to an interrupt output of one or more processors. Every shared source owns a routing word and a processor-select word. The routing word picks one of up to 64 numbered pins, or the non-maskable line, or the yield line. The processor-select word is a bitmap with one bit per processor. Each processor also owns a small group of local sources, such as its timer, its performance counter and its software interrupts. These local sources go only to their own processor, and each one is gated by its own enable bit.

A single 32-bit write port sets up all of this state. Each processor receives a registered vector of numbered pins plus one non-maskable output and one yield output. Many sources may share a pin, and that pin is then the OR of all of them. Sources with no route, or with no selected processor, drive nothing. Vector or priority encoding after the pins belongs to the processor side and is not part of this block.

Top module: `irq_route_map`

## Requirements
- R1: The routing word of shared source n is written at byte address MAP_BASE + 4*n (default MAP_BASE = 0x0500). When bit 31 is set and bits 30 and 29 are clear, the source drives numbered pin bits[5:0] (0 to 63).
- R2: Bit 30 of a routing word routes the source to the non-maskable output, and bit 29 routes it to the yield output. Exactly one destination is taken, in priority order non-maskable, then yield, then numbered pin. A word with none of bits 31, 30 or 29 set drives nothing.
- R3: The processor-select word of shared source n is at SEL_BASE + 32*n (default 0x2000). Bit v delivers the source to processor v, every set bit delivers a copy, and a zero word delivers it nowhere.
- R4: Output pin p of processor v is the OR of every qualified source that routes to pin p of that processor.
- R5: Reset clears every routing word, every select word and every local enable, and all outputs are low even while sources are pending.
- R6: Outputs are registered. A change of a pending input shows at the outputs after the next rising edge. A configuration write becomes effective one edge after the edge that stores it.
- R7: Local source k of processor v has its routing word at LOC_BASE + v*LOC_STRIDE + 0x40 + 4*k (defaults 0x8000 and 0x100). It reaches only processor v, and only while its enable bit is set.
- R8: A write to LOC_BASE + v*LOC_STRIDE + 0x10 sets the local enable bits of processor v wherever the data bit is 1. A write to offset 0x0C clears them wherever the data bit is 1. Zero data bits leave the enables unchanged.
- R9: Writes to any address that is not listed above change no state. This includes misaligned addresses and select words beyond the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 16 | Byte address of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| src_pend | input | N_SRC | Masked pending shared sources |
| loc_pend | input | N_PROC*N_LOC | Pending local sources, processor v at bits v*N_LOC and up |
| irq_pin | output | N_PROC*N_PINS | Numbered pins, processor v at bits v*N_PINS and up |
| irq_nmi | output | N_PROC | Non-maskable output per processor |
| irq_yield | output | N_PROC | Yield output per processor |

## Verification
A routing rewrite and a pending source that is already asserted can act on the same clock edge. The bench provokes this by holding a source asserted on one pin and storing a routing word that points it to another pin. It then checks that the edge that stores the word still shows the old pin, and that the following edge moves the output to the new pin only. A local enable write that lands while its local source is pending is handled the same way: the output must change exactly one edge after the write.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   localparam int PIN_FLAG_BIT = 31;
   localparam int NMI_FLAG_BIT = 30;
   localparam int YLD_FLAG_BIT = 29;
   localparam int NUM_W        = 6;

   typedef struct packed {
      logic             to_pin;
      logic             to_nmi;
      logic             to_yld;
      logic [NUM_W-1:0] num;
   } route_t;

   function automatic route_t to_route(input logic [31:0] w);
      route_t r;
      r.to_pin = w[PIN_FLAG_BIT];
      r.to_nmi = w[NMI_FLAG_BIT];
      r.to_yld = w[YLD_FLAG_BIT];
      r.num    = w[NUM_W-1:0];
      return r;
   endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
   import irq_route_pkg::*;
#(
   parameter int N_PINS = 64,
   localparam int DW    = N_PINS + 2
) (
   input  route_t          rt,
   output logic [DW-1:0]   dest
);

   always_comb begin
      dest = '0;
      if (rt.to_nmi) begin
         dest[N_PINS] = 1'b1;
      end else if (rt.to_yld) begin
         dest[N_PINS+1] = 1'b1;
      end else if (rt.to_pin && (int'(rt.num) < N_PINS)) begin
         dest[rt.num] = 1'b1;
      end
   end

endmodule

// File: rtl/irq_route_cfg.sv
module irq_route_cfg
   import irq_route_pkg::*;
#(
   parameter int N_SRC      = 8,
   parameter int N_PROC     = 2,
   parameter int N_LOC      = 4,
   parameter int AW         = 16,
   parameter int MAP_BASE   = 'h0500,
   parameter int SEL_BASE   = 'h2000,
   parameter int LOC_BASE   = 'h8000,
   parameter int LOC_STRIDE = 'h0100,
   localparam int N_LT      = N_PROC * N_LOC,
   localparam int CLR_OFS   = 'h0C,
   localparam int SET_OFS   = 'h10,
   localparam int LMAP_OFS  = 'h40
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic [AW-1:0]                cfg_addr,
   input  logic [31:0]                  cfg_wdata,
   output route_t [N_SRC-1:0]           map_q,
   output logic [N_SRC-1:0][N_PROC-1:0] sel_q,
   output route_t [N_LT-1:0]            lmap_q,
   output logic [N_LT-1:0]              lmask_q
);

   logic [N_SRC-1:0]  hit_map, hit_sel;
   logic [N_PROC-1:0] hit_set, hit_clr;
   logic [N_LT-1:0]   hit_lmap;

   always_comb begin
      for (int n = 0; n < N_SRC; n++) begin
         hit_map[n] = cfg_we && (cfg_addr == AW'(MAP_BASE + 4*n));
         hit_sel[n] = cfg_we && (cfg_addr == AW'(SEL_BASE + 32*n));
      end
      for (int v = 0; v < N_PROC; v++) begin
         hit_clr[v] = cfg_we && (cfg_addr == AW'(LOC_BASE + v*LOC_STRIDE + CLR_OFS));
         hit_set[v] = cfg_we && (cfg_addr == AW'(LOC_BASE + v*LOC_STRIDE + SET_OFS));
         for (int k = 0; k < N_LOC; k++) begin
            hit_lmap[v*N_LOC+k] = cfg_we &&
               (cfg_addr == AW'(LOC_BASE + v*LOC_STRIDE + LMAP_OFS + 4*k));
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         map_q   <= '0;
         sel_q   <= '0;
         lmap_q  <= '0;
         lmask_q <= '0;
      end else begin
         for (int n = 0; n < N_SRC; n++) begin
            if (hit_map[n]) map_q[n] <= to_route(cfg_wdata);
            if (hit_sel[n]) sel_q[n] <= cfg_wdata[N_PROC-1:0];
         end
         for (int v = 0; v < N_PROC; v++) begin
            for (int k = 0; k < N_LOC; k++) begin
               if (hit_lmap[v*N_LOC+k]) lmap_q[v*N_LOC+k] <= to_route(cfg_wdata);
               if (hit_set[v] && cfg_wdata[k])      lmask_q[v*N_LOC+k] <= 1'b1;
               else if (hit_clr[v] && cfg_wdata[k]) lmask_q[v*N_LOC+k] <= 1'b0;
            end
         end
      end
   end

   // R9
   idle_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(map_q) && $stable(sel_q) && $stable(lmap_q) && $stable(lmask_q)));

   for (genvar gv = 0; gv < N_PROC; gv++) begin : g_mchk
      for (genvar gk = 0; gk < N_LOC; gk++) begin : g_bit
         // R8
         set_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == AW'(LOC_BASE + gv*LOC_STRIDE + SET_OFS) && cfg_wdata[gk])
            |=> lmask_q[gv*N_LOC+gk]);
         // R8
         clr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == AW'(LOC_BASE + gv*LOC_STRIDE + CLR_OFS) && cfg_wdata[gk])
            |=> !lmask_q[gv*N_LOC+gk]);
      end
   end

endmodule

// File: rtl/irq_route_combine.sv
module irq_route_combine #(
   parameter int N_SRC  = 8,
   parameter int N_PROC = 2,
   parameter int N_LOC  = 4,
   parameter int N_PINS = 64,
   localparam int DW    = N_PINS + 2,
   localparam int N_LT  = N_PROC * N_LOC
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_SRC-1:0]             src_pend,
   input  logic [N_SRC-1:0][N_PROC-1:0] sel,
   input  logic [N_SRC-1:0][DW-1:0]     sdest,
   input  logic [N_LT-1:0]              loc_pend,
   input  logic [N_LT-1:0]              lmask,
   input  logic [N_LT-1:0][DW-1:0]      ldest,
   output logic [N_PROC*N_PINS-1:0]     irq_pin,
   output logic [N_PROC-1:0]            irq_nmi,
   output logic [N_PROC-1:0]            irq_yield
);

   logic [N_PROC-1:0][DW-1:0] acc, out_q;

   always_comb begin
      acc = '0;
      for (int v = 0; v < N_PROC; v++) begin
         for (int n = 0; n < N_SRC; n++) begin
            if (src_pend[n] && sel[n][v]) acc[v] = acc[v] | sdest[n];
         end
         for (int k = 0; k < N_LOC; k++) begin
            if (loc_pend[v*N_LOC+k] && lmask[v*N_LOC+k]) acc[v] = acc[v] | ldest[v*N_LOC+k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= acc;
   end

   for (genvar gv = 0; gv < N_PROC; gv++) begin : g_out
      assign irq_pin[gv*N_PINS +: N_PINS] = out_q[gv][N_PINS-1:0];
      assign irq_nmi[gv]                  = out_q[gv][N_PINS];
      assign irq_yield[gv]                = out_q[gv][N_PINS+1];

      // R3
      no_target_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (((src_pend & {N_SRC{1'b1}}) == 0 || sel == '0) &&
          (loc_pend[gv*N_LOC +: N_LOC] & lmask[gv*N_LOC +: N_LOC]) == '0)
         |=> (irq_pin[gv*N_PINS +: N_PINS] == '0 && !irq_nmi[gv] && !irq_yield[gv]));
   end

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_pend == '0 && (loc_pend & lmask) == '0)
      |=> (irq_pin == '0 && irq_nmi == '0 && irq_yield == '0));

   // R7
   local_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_pend == '0 && lmask == '0)
      |=> (irq_pin == '0 && irq_nmi == '0 && irq_yield == '0));

endmodule

// File: rtl/irq_route_map.sv
module irq_route_map
   import irq_route_pkg::*;
#(
   parameter int N_SRC      = 8,
   parameter int N_PROC     = 2,
   parameter int N_LOC      = 4,
   parameter int N_PINS     = 64,
   parameter int AW         = 16,
   parameter int MAP_BASE   = 'h0500,
   parameter int SEL_BASE   = 'h2000,
   parameter int LOC_BASE   = 'h8000,
   parameter int LOC_STRIDE = 'h0100
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [AW-1:0]             cfg_addr,
   input  logic [31:0]               cfg_wdata,
   input  logic [N_SRC-1:0]          src_pend,
   input  logic [N_PROC*N_LOC-1:0]   loc_pend,
   output logic [N_PROC*N_PINS-1:0]  irq_pin,
   output logic [N_PROC-1:0]         irq_nmi,
   output logic [N_PROC-1:0]         irq_yield
);

   localparam int DW   = N_PINS + 2;
   localparam int N_LT = N_PROC * N_LOC;

   if (N_PINS < 1 || N_PINS > 64) begin : g_bad_pins
      $error("N_PINS must lie in 1..64");
   end
   if (N_PROC < 1 || N_PROC > 32) begin : g_bad_proc
      $error("N_PROC must lie in 1..32");
   end
   if (N_LOC < 1 || 'h40 + 4*N_LOC > LOC_STRIDE) begin : g_bad_loc
      $error("local words overflow LOC_STRIDE");
   end
   if (MAP_BASE + 4*N_SRC > SEL_BASE || SEL_BASE + 32*N_SRC > LOC_BASE) begin : g_bad_map
      $error("address windows overlap");
   end
   if (LOC_BASE + N_PROC*LOC_STRIDE > (1 << AW)) begin : g_bad_aw
      $error("AW too narrow for the local windows");
   end

   route_t [N_SRC-1:0]           map_q;
   logic [N_SRC-1:0][N_PROC-1:0] sel_q;
   route_t [N_LT-1:0]            lmap_q;
   logic [N_LT-1:0]              lmask_q;
   logic [N_SRC-1:0][DW-1:0]     sdest;
   logic [N_LT-1:0][DW-1:0]      ldest;

   irq_route_cfg #(
      .N_SRC(N_SRC), .N_PROC(N_PROC), .N_LOC(N_LOC), .AW(AW),
      .MAP_BASE(MAP_BASE), .SEL_BASE(SEL_BASE),
      .LOC_BASE(LOC_BASE), .LOC_STRIDE(LOC_STRIDE)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .map_q(map_q), .sel_q(sel_q),
      .lmap_q(lmap_q), .lmask_q(lmask_q)
   );

   for (genvar gn = 0; gn < N_SRC; gn++) begin : g_sdec
      irq_route_decode #(.N_PINS(N_PINS)) u_dec (.rt(map_q[gn]), .dest(sdest[gn]));
   end

   for (genvar gl = 0; gl < N_LT; gl++) begin : g_ldec
      irq_route_decode #(.N_PINS(N_PINS)) u_dec (.rt(lmap_q[gl]), .dest(ldest[gl]));
   end

   irq_route_combine #(
      .N_SRC(N_SRC), .N_PROC(N_PROC), .N_LOC(N_LOC), .N_PINS(N_PINS)
   ) u_comb (
      .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .sel(sel_q), .sdest(sdest),
      .loc_pend(loc_pend), .lmask(lmask_q), .ldest(ldest),
      .irq_pin(irq_pin), .irq_nmi(irq_nmi), .irq_yield(irq_yield)
   );

   for (genvar gv = 0; gv < N_PROC; gv++) begin : g_prio
      // R2
      one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($countones(src_pend) == 1 && $countones(loc_pend & lmask_q) == 0)
         |=> ($countones({irq_nmi[gv], irq_yield[gv], irq_pin[gv*N_PINS +: N_PINS]}) <= 1));
   end

endmodule

// File: tb/irq_route_map_bench.sv
module irq_route_map_bench;

   localparam int N_SRC = 8, N_PROC = 2, N_LOC = 4, N_PINS = 64;
   localparam int SW = N_PROC*N_PINS + 2*N_PROC;

   logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
   logic [15:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [N_SRC-1:0] src_pend = '0;
   logic [N_PROC*N_LOC-1:0] loc_pend = '0;
   logic [N_PROC*N_PINS-1:0] irq_pin;
   logic [N_PROC-1:0] irq_nmi, irq_yield;

   int errors = 0, checks = 0;

   always #2.5 clk = ~clk;

   irq_route_map u_irq_route_map (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .src_pend(src_pend), .loc_pend(loc_pend),
      .irq_pin(irq_pin), .irq_nmi(irq_nmi), .irq_yield(irq_yield)
   );

   // kind: 0 none, 1 pin num, 2 non-maskable, 3 yield
   typedef struct packed {
      logic [31:0] map;
      logic [1:0]  sel;
      logic [1:0]  kind;
      logic [5:0]  num;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{32'h8000_0005, 2'b01, 2'd1, 6'd5},   // R1
      '{32'h8000_003F, 2'b10, 2'd1, 6'd63},  // R1 top pin
      '{32'h4000_0000, 2'b01, 2'd2, 6'd0},   // R2 nmi
      '{32'h2000_0000, 2'b10, 2'd3, 6'd0},   // R2 yield
      '{32'hC000_0007, 2'b01, 2'd2, 6'd0},   // R2 nmi beats pin
      '{32'hA000_0009, 2'b01, 2'd3, 6'd0},   // R2 yield beats pin
      '{32'h6000_0000, 2'b10, 2'd2, 6'd0},   // R2 nmi beats yield
      '{32'h0000_000C, 2'b01, 2'd0, 6'd0},   // R2 no flag
      '{32'h8000_0011, 2'b00, 2'd0, 6'd0},   // R3 no processor
      '{32'h8000_0002, 2'b11, 2'd1, 6'd2}    // R3 both processors
   };

   function automatic logic [SW-1:0] snap();
      return {irq_yield, irq_nmi, irq_pin};
   endfunction

   function automatic logic [SW-1:0] expect_of(int v, int kind, int num);
      logic [SW-1:0] e = '0;
      case (kind)
         1: e[v*N_PINS + num] = 1'b1;
         2: e[N_PROC*N_PINS + v] = 1'b1;
         3: e[N_PROC*N_PINS + N_PROC + v] = 1'b1;
         default: ;
      endcase
      return e;
   endfunction

   task automatic chk(string req, logic [SW-1:0] got, logic [SW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(int addr, logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 16'(addr); cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [SW-1:0] e;
      // R5 reset state with everything pending
      src_pend = '1; loc_pend = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R5", snap(), '0);
      src_pend = '0; loc_pend = '0;

      // vector walk
      for (int i = 0; i < NV; i++) begin
         int s = i % N_SRC;
         wr('h0500 + 4*s, VEC[i].map);
         wr('h2000 + 32*s, {30'b0, VEC[i].sel});
         src_pend = N_SRC'(1) << s;
         @(negedge clk);
         e = '0;
         for (int v = 0; v < N_PROC; v++)
            if (VEC[i].sel[v]) e = e | expect_of(v, int'(VEC[i].kind), int'(VEC[i].num));
         chk(i < 7 ? "R1/R2 vector" : "R3 vector", snap(), e);
         src_pend = '0;
         wr('h0500 + 4*s, 32'h0);
         wr('h2000 + 32*s, 32'h0);
      end

      // R4 two sources share pin 10 on processor 0
      wr('h0504, 32'h8000_000A); wr('h2020, 32'h1);
      wr('h0508, 32'h8000_000A); wr('h2040, 32'h1);
      src_pend = 8'b0000_0100;
      @(negedge clk);
      chk("R4 one of two", snap(), expect_of(0, 1, 10));
      src_pend = 8'b0000_0110;
      @(negedge clk);
      chk("R4 both", snap(), expect_of(0, 1, 10));
      src_pend = '0;
      @(negedge clk);
      chk("R4 none", snap(), '0);

      // R6 latency and rewrite on the same edge
      wr('h0500, 32'h8000_0003); wr('h2000, 32'h1);
      src_pend = 8'b0000_0001;
      #1;
      chk("R6 before edge", snap(), '0);
      @(negedge clk);
      chk("R6 after edge", snap(), expect_of(0, 1, 3));
      wr('h0500, 32'h8000_0004);
      chk("R6 old route on store edge", snap(), expect_of(0, 1, 3));
      @(negedge clk);
      chk("R6 new route", snap(), expect_of(0, 1, 4));

      // R9 ignored writes keep source 0 on pin 4 of processor 0
      wr('h0502, 32'h4000_0000);
      wr('h2004, 32'hFFFF_FFFF);
      wr('h0700, 32'h2000_0000);
      chk("R9", snap(), expect_of(0, 1, 4));
      src_pend = '0;
      wr('h0500, 32'h0); wr('h2000, 32'h0);

      // R7 local source 2 of processor 1 on pin 20
      wr('h8148, 32'h8000_0014);
      loc_pend = 8'b0100_0000;
      @(negedge clk);
      chk("R7 disabled", snap(), '0);
      wr('h8110, 32'h4);
      chk("R8 set on store edge", snap(), '0);
      @(negedge clk);
      chk("R7 enabled", snap(), expect_of(1, 1, 20));
      wr('h8110, 32'h0);
      @(negedge clk);
      chk("R8 zero set keeps", snap(), expect_of(1, 1, 20));
      wr('h810C, 32'h0);
      @(negedge clk);
      chk("R8 zero clear keeps", snap(), expect_of(1, 1, 20));
      wr('h800C, 32'hF);
      @(negedge clk);
      chk("R7 other processor clear", snap(), expect_of(1, 1, 20));
      wr('h810C, 32'h4);
      @(negedge clk);
      chk("R8 clear", snap(), '0);
      loc_pend = '0;

      // R7 local word of processor 0 goes to non-maskable on processor 0 only
      wr('h8040, 32'h4000_0000);
      wr('h8010, 32'h1);
      loc_pend = 8'b0000_0001;
      @(negedge clk);
      chk("R7 local nmi", snap(), expect_of(0, 2, 0));
      loc_pend = '0;
      @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule